// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the 32-bit integer registers of a small processor whose physical storage depends on the current operating mode. Software sees sixteen logical registers, 0 to 15. Indices 0 to 14 map onto a pool of thirty physical words. Only some of those words are swapped when the mode changes. Index 15 is the program counter, which lives outside the block: it is read from an input and written through an output strobe.

The fast-interrupt mode has private copies of indices 8 to 14. Each of the other four exception modes (interrupt, supervisor, abort, undefined) has private copies of only the stack pointer (13) and the link register (14). User and System modes share one set with no private copies.

Each exception mode also owns one saved-status word. It is reached through a dedicated read/write port that always addresses the word of the current mode. There are two combinational read ports and one write port. Writes land on the rising clock edge.

Top module: `banked_regfile`

## Requirements
- R1: After reset every physical general register and every saved-status word reads as zero in every mode.
- R2: The 5-bit mode input decodes as follows: 10000 User, 10001 fast interrupt, 10010 interrupt, 10011 supervisor, 10111 abort, 11011 undefined, 11111 System. Any other value maps registers exactly as User does and has no saved-status word.
- R3: Logical registers 0 to 7 are one physical set shared by every mode.
- R4: In fast-interrupt mode (10001), indices 8 to 14 address seven private words. Writes there leave the User copies unchanged, and the reverse holds too.
- R5: In each of the interrupt, supervisor, abort and undefined modes, indices 13 and 14 address two words private to that mode. Indices 8 to 12 address the User copies.
- R6: System mode (11111) reads and writes exactly the same physical words as User mode for indices 0 to 14.
- R7: Each of the five exception modes has its own saved-status word. A write through the saved-status port in that mode is read back in that mode from the next cycle on, and does not disturb the other four words.
- R8: In User mode, in System mode and in any undecoded mode, a saved-status write is ignored and the saved-status read returns all zeros.
- R9: A read of a register in the same cycle as a write to it returns the old value. The new value appears from the following cycle.
- R10: Reading index 15 on either port returns the pc_i input. A write to index 15 raises pc_wr_o for that cycle with the data on pc_wr_data_o, and changes no stored register.
- R11: The two read ports select independently and may address any pair of indices in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 5 | Current operating mode |
| rd_a_idx_i | input | 4 | Logical index for read port A |
| rd_a_data_o | output | 32 | Read port A data, combinational |
| rd_b_idx_i | input | 4 | Logical index for read port B |
| rd_b_data_o | output | 32 | Read port B data, combinational |
| wr_en_i | input | 1 | Register write enable |
| wr_idx_i | input | 4 | Logical index for the write |
| wr_data_i | input | 32 | Write data |
| pc_i | input | 32 | Program counter value presented as index 15 |
| pc_wr_o | output | 1 | Strobe: a write addressed index 15 this cycle |
| pc_wr_data_o | output | 32 | Data carried with pc_wr_o |
| sr_wr_en_i | input | 1 | Saved-status write enable for the current mode |
| sr_wr_data_i | input | 32 | Saved-status write data |
| sr_rd_data_o | output | 32 | Saved-status word of the current mode, or zero |

## Verification
The write-visibility properties assume that the mode input is held between the write cycle and the read cycle. They fire only when it is, because a mode change may legally remap the same index onto another physical word. The stimulus keeps the mode input constant within each cycle and changes it only between clock edges. It then either holds the mode for readback or moves deliberately to another mode, to show that banked words are separate. The random phase mixes all seven decoded modes with arbitrary undecoded values. It issues writes to every index including 15, together with saved-status writes, so the checks that writes are ignored in non-exception modes and that the program-counter strobe works are exercised under mixed traffic.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int MODE_W      = 5;
  localparam int IDX_W       = 4;
  localparam int PC_IDX      = 15;
  localparam int SHARED_REGS = 15;
  localparam int FIQ_FIRST   = 8;
  localparam int FIQ_PRIV    = SHARED_REGS - FIQ_FIRST;
  localparam int SP_IDX      = 13;
  localparam int EXC_PRIV    = 2;
  localparam int NUM_SMALL   = 4;
  localparam int NUM_SR      = NUM_SMALL + 1;
  localparam int FIQ_BASE    = SHARED_REGS;
  localparam int EXC_BASE    = FIQ_BASE + FIQ_PRIV;
  localparam int NUM_PHYS    = EXC_BASE + EXC_PRIV * NUM_SMALL;
  localparam int PHYS_W      = $clog2(NUM_PHYS);

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;
endpackage

// File: rtl/rf_reset_sync.sv
module rf_reset_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/rf_mode_decode.sv
module rf_mode_decode
  import rf_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output bank_e             bank_o
);
  always_comb begin
    unique case (mode_i)
      MODE_FIQ: bank_o = BK_FIQ;
      MODE_IRQ: bank_o = BK_IRQ;
      MODE_SVC: bank_o = BK_SVC;
      MODE_ABT: bank_o = BK_ABT;
      MODE_UND: bank_o = BK_UND;
      default:  bank_o = BK_USR;  // user, system and undecoded values
    endcase
  end
endmodule

// File: rtl/rf_bank_map.sv
module rf_bank_map
  import rf_pkg::*;
(
  input  bank_e             bank_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [PHYS_W-1:0] phys_o,
  output logic              is_pc_o
);
  logic fiq_hit;
  logic exc_hit;

  always_comb begin
    is_pc_o = (int'(idx_i) == PC_IDX);
    fiq_hit = (bank_i == BK_FIQ) && (int'(idx_i) >= FIQ_FIRST) && !is_pc_o;
    exc_hit = (int'(bank_i) >= int'(BK_IRQ)) && (int'(idx_i) >= SP_IDX) && !is_pc_o;
    if (is_pc_o) begin
      phys_o = '0;
    end else if (fiq_hit) begin
      phys_o = PHYS_W'(FIQ_BASE + int'(idx_i) - FIQ_FIRST);
    end else if (exc_hit) begin
      phys_o = PHYS_W'(EXC_BASE + (int'(bank_i) - int'(BK_IRQ)) * EXC_PRIV
                       + int'(idx_i) - SP_IDX);
    end else begin
      phys_o = PHYS_W'(idx_i);
    end
  end
endmodule

// File: rtl/rf_gpr_array.sv
module rf_gpr_array #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 30,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [AW-1:0]     raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);
  logic [DEPTH-1:0][DATA_W-1:0] word_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic              en;
    logic [DATA_W-1:0] q;
    assign en = we_i && (waddr_i == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wdata_i;
    end
    assign word_q[i] = q;
  end

  always_comb begin
    rdata_a_o = '0;
    rdata_b_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (raddr_a_i == AW'(i)) rdata_a_o = word_q[i];
      if (raddr_b_i == AW'(i)) rdata_b_o = word_q[i];
    end
  end
endmodule

// File: rtl/rf_sr_bank.sv
module rf_sr_bank
  import rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bank_e             bank_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [NUM_SR-1:0][DATA_W-1:0] sr_q;

  for (genvar i = 0; i < NUM_SR; i++) begin : g_sr
    logic              en;
    logic [DATA_W-1:0] q;
    assign en = we_i && (bank_i == bank_e'(i + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wdata_i;
    end
    assign sr_q[i] = q;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_SR; i++) begin
      if (bank_i == bank_e'(i + 1)) rdata_o = sr_q[i];
    end
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        mode_i,
  input  logic [3:0]        rd_a_idx_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [3:0]        rd_b_idx_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] pc_i,
  output logic              pc_wr_o,
  output logic [DATA_W-1:0] pc_wr_data_o,
  input  logic              sr_wr_en_i,
  input  logic [DATA_W-1:0] sr_wr_data_i,
  output logic [DATA_W-1:0] sr_rd_data_o
);
  logic rst_sync_n;
  bank_e bank;

  logic [PHYS_W-1:0] ph_a, ph_b, ph_w;
  logic              pc_a, pc_b, pc_w;
  logic [DATA_W-1:0] arr_a, arr_b;
  logic              arr_we;

  rf_reset_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  rf_mode_decode u_dec (
    .mode_i (mode_i),
    .bank_o (bank)
  );

  rf_bank_map u_map_a (.bank_i(bank), .idx_i(rd_a_idx_i), .phys_o(ph_a), .is_pc_o(pc_a));
  rf_bank_map u_map_b (.bank_i(bank), .idx_i(rd_b_idx_i), .phys_o(ph_b), .is_pc_o(pc_b));
  rf_bank_map u_map_w (.bank_i(bank), .idx_i(wr_idx_i),   .phys_o(ph_w), .is_pc_o(pc_w));

  assign arr_we       = wr_en_i && !pc_w;
  assign pc_wr_o      = wr_en_i && pc_w;
  assign pc_wr_data_o = wr_data_i;

  rf_gpr_array #(.DATA_W(DATA_W), .DEPTH(NUM_PHYS)) u_gpr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .we_i      (arr_we),
    .waddr_i   (ph_w),
    .wdata_i   (wr_data_i),
    .raddr_a_i (ph_a),
    .rdata_a_o (arr_a),
    .raddr_b_i (ph_b),
    .rdata_b_o (arr_b)
  );

  assign rd_a_data_o = pc_a ? pc_i : arr_a;
  assign rd_b_data_o = pc_b ? pc_i : arr_b;

  rf_sr_bank #(.DATA_W(DATA_W)) u_sr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .bank_i  (bank),
    .we_i    (sr_wr_en_i),
    .wdata_i (sr_wr_data_i),
    .rdata_o (sr_rd_data_o)
  );
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        mode_i,
  input logic [3:0]        rd_a_idx_i,
  input logic [DATA_W-1:0] rd_a_data_o,
  input logic [3:0]        rd_b_idx_i,
  input logic [DATA_W-1:0] rd_b_data_o,
  input logic              wr_en_i,
  input logic [3:0]        wr_idx_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] pc_i,
  input logic              pc_wr_o,
  input logic [DATA_W-1:0] pc_wr_data_o,
  input logic              sr_wr_en_i,
  input logic [DATA_W-1:0] sr_wr_data_i,
  input logic [DATA_W-1:0] sr_rd_data_o
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  function automatic logic is_exc(input logic [4:0] m);
    return (m == 5'b10001) || (m == 5'b10010) || (m == 5'b10011) ||
           (m == 5'b10111) || (m == 5'b11011);
  endfunction

  // R10: index 15 reads the external program counter on both ports
  a_r10_pc_read_a: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx_i == 4'd15) |-> (rd_a_data_o == pc_i));
  a_r10_pc_read_b: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_idx_i == 4'd15) |-> (rd_b_data_o == pc_i));

  // R10: the strobe only accompanies a write to index 15, carrying its data
  a_r10_pc_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_o |-> (wr_en_i && (wr_idx_i == 4'd15) && (pc_wr_data_o == wr_data_i)));

  // R8: no saved-status word outside the exception modes
  a_r8_sr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !is_exc(mode_i) |-> (sr_rd_data_o == '0));

  // R9: a register write is visible one cycle later under an unchanged mode
  a_r9_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(wr_en_i) && ($past(wr_idx_i) != 4'd15) &&
     (rd_a_idx_i == $past(wr_idx_i)) && (mode_i == $past(mode_i)))
    |-> (rd_a_data_o == $past(wr_data_i)));

  // R7: a saved-status write in an exception mode reads back next cycle
  a_r7_sr_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(sr_wr_en_i) && is_exc($past(mode_i)) &&
     (mode_i == $past(mode_i)))
    |-> (sr_rd_data_o == $past(sr_wr_data_i)));
endmodule

bind banked_regfile rf_checker #(.DATA_W(DATA_W)) u_rf_checker (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .mode_i       (mode_i),
  .rd_a_idx_i   (rd_a_idx_i),
  .rd_a_data_o  (rd_a_data_o),
  .rd_b_idx_i   (rd_b_idx_i),
  .rd_b_data_o  (rd_b_data_o),
  .wr_en_i      (wr_en_i),
  .wr_idx_i     (wr_idx_i),
  .wr_data_i    (wr_data_i),
  .pc_i         (pc_i),
  .pc_wr_o      (pc_wr_o),
  .pc_wr_data_o (pc_wr_data_o),
  .sr_wr_en_i   (sr_wr_en_i),
  .sr_wr_data_i (sr_wr_data_i),
  .sr_rd_data_o (sr_rd_data_o)
);

// File: tb/test_banked_regfile.sv
module test_banked_regfile;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [4:0]  mode;
  logic [3:0]  ra, rb, wi;
  logic [31:0] rda, rdb, wd, pc, pcwd, swd, srd;
  logic        we, pcw, swe;

  int n_checks = 0;
  int n_fail   = 0;

  banked_regfile i_banked_regfile (
    .clk(clk), .rst_n(rst_n), .mode_i(mode),
    .rd_a_idx_i(ra), .rd_a_data_o(rda), .rd_b_idx_i(rb), .rd_b_data_o(rdb),
    .wr_en_i(we), .wr_idx_i(wi), .wr_data_i(wd), .pc_i(pc),
    .pc_wr_o(pcw), .pc_wr_data_o(pcwd),
    .sr_wr_en_i(swe), .sr_wr_data_i(swd), .sr_rd_data_o(srd)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // behavioural reference: separate storage per visible role
  logic [31:0] m_usr [15];
  logic [31:0] m_fiq [7];
  logic [31:0] m_bk  [4][2];
  logic [31:0] m_sr  [5];

  logic [4:0] all_modes [7] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                5'b10111, 5'b11011, 5'b11111};
  logic [4:0] exc_modes [5] = '{5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011};
  logic [4:0] small_modes [4] = '{5'b10010, 5'b10011, 5'b10111, 5'b11011};

  function automatic int bk(input logic [4:0] m);
    case (m)
      5'b10001: return 1;
      5'b10010: return 2;
      5'b10011: return 3;
      5'b10111: return 4;
      5'b11011: return 5;
      default:  return 0;
    endcase
  endfunction

  function automatic logic [31:0] m_rd(input logic [4:0] m, input int idx);
    int b = bk(m);
    if (idx == 15) return pc;
    if (b == 1 && idx >= 8) return m_fiq[idx-8];
    if (b >= 2 && idx >= 13) return m_bk[b-2][idx-13];
    return m_usr[idx];
  endfunction

  function automatic logic [31:0] m_srd(input logic [4:0] m);
    int b = bk(m);
    if (b == 0) return 32'h0;
    return m_sr[b-1];
  endfunction

  task automatic m_wr(input logic [4:0] m, input int idx, input logic [31:0] d);
    int b = bk(m);
    if (idx == 15) return;
    if (b == 1 && idx >= 8) m_fiq[idx-8] = d;
    else if (b >= 2 && idx >= 13) m_bk[b-2][idx-13] = d;
    else m_usr[idx] = d;
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h (mode %b)", tag, what, got, exp, mode);
    end
  endtask

  // compare all outputs before the edge, then advance the model at the edge
  task automatic tick(input string tag);
    @(negedge clk);
    chk(tag, "port A", rda, m_rd(mode, int'(ra)));
    chk(tag, "port B", rdb, m_rd(mode, int'(rb)));
    chk(tag, "saved status", srd, m_srd(mode));
    chk(tag, "pc strobe", {31'b0, pcw}, {31'b0, (we && wi == 4'd15)});
    if (we && wi == 4'd15) chk(tag, "pc data", pcwd, wd);
    @(posedge clk);
    if (we) m_wr(mode, int'(wi), wd);
    if (swe && bk(mode) != 0) m_sr[bk(mode)-1] = swd;
    #1;
  endtask

  task automatic go(input logic [4:0] m, input int a, input int b,
                    input bit w, input int widx, input logic [31:0] wdat,
                    input bit sw, input logic [31:0] sdat, input string tag);
    mode = m; ra = 4'(a); rb = 4'(b);
    we = w; wi = 4'(widx); wd = wdat;
    swe = sw; swd = sdat;
    tick(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 15; i++) m_usr[i] = '0;
    for (int i = 0; i < 7; i++)  m_fiq[i] = '0;
    for (int i = 0; i < 4; i++) begin m_bk[i][0] = '0; m_bk[i][1] = '0; end
    for (int i = 0; i < 5; i++)  m_sr[i] = '0;
    rst_n = 1'b0; mode = 5'b10000; ra = '0; rb = '0; we = 1'b0; wi = '0;
    wd = '0; swe = 1'b0; swd = '0; pc = 32'h0000_1000;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // R1: reset contents
    for (int i = 0; i < 15; i++) go(5'b10000, i, 14 - i, 0, 0, 0, 0, 0, "R1");
    for (int k = 0; k < 5; k++) go(exc_modes[k], 13, 14, 0, 0, 0, 0, 0, "R1");
    go(5'b10001, 8, 12, 0, 0, 0, 0, 0, "R1");

    // R3: low registers shared everywhere
    for (int i = 0; i < 8; i++) go(5'b10000, 0, 1, 1, i, 32'h1000_0000 + i, 0, 0, "R3");
    for (int k = 0; k < 7; k++)
      for (int i = 0; i < 8; i++) go(all_modes[k], i, 7 - i, 0, 0, 0, 0, 0, "R3");
    go(5'b10001, 3, 4, 1, 3, 32'h1300_0003, 0, 0, "R3");
    go(5'b10000, 3, 4, 0, 0, 0, 0, 0, "R3");

    // R4: fast-interrupt private 8..14
    for (int i = 8; i < 15; i++) go(5'b10000, 0, 0, 1, i, 32'h2000_0000 + i, 0, 0, "R4");
    for (int i = 8; i < 15; i++) go(5'b10001, 0, 0, 1, i, 32'h3000_0000 + i, 0, 0, "R4");
    for (int i = 8; i < 15; i++) go(5'b10001, i, 22 - i, 0, 0, 0, 0, 0, "R4");
    for (int i = 8; i < 15; i++) go(5'b10000, i, 22 - i, 0, 0, 0, 0, 0, "R4");

    // R5: small banks private 13/14, shared 8..12
    for (int k = 0; k < 4; k++) begin
      go(small_modes[k], 0, 0, 1, 13, 32'h4000_0013 + k * 256, 0, 0, "R5");
      go(small_modes[k], 0, 0, 1, 14, 32'h4000_0014 + k * 256, 0, 0, "R5");
    end
    for (int k = 0; k < 4; k++) begin
      go(small_modes[k], 13, 14, 0, 0, 0, 0, 0, "R5");
      for (int i = 8; i < 13; i++) go(small_modes[k], i, 13, 0, 0, 0, 0, 0, "R5");
    end
    go(5'b10000, 13, 14, 0, 0, 0, 0, 0, "R5");
    go(5'b10001, 13, 14, 0, 0, 0, 0, 0, "R5");

    // R6: system equals user
    for (int i = 0; i < 15; i++) go(5'b11111, i, i, 0, 0, 0, 0, 0, "R6");
    go(5'b11111, 13, 14, 1, 13, 32'h5000_0013, 0, 0, "R6");
    go(5'b10000, 13, 14, 0, 0, 0, 0, 0, "R6");
    go(5'b10000, 0, 0, 1, 10, 32'h5000_0010, 0, 0, "R6");
    go(5'b11111, 10, 13, 0, 0, 0, 0, 0, "R6");

    // R2: decode, undecoded values behave as user
    go(5'b10100, 13, 9, 0, 0, 0, 0, 0, "R2");
    go(5'b00000, 14, 8, 1, 14, 32'h2222_0014, 0, 0, "R2");
    go(5'b10000, 14, 8, 0, 0, 0, 0, 0, "R2");
    go(5'b11011, 13, 14, 0, 0, 0, 0, 0, "R2");
    go(5'b10110, 13, 14, 0, 0, 0, 1, 32'hBAD0_0001, "R2");

    // R7: per-mode saved status
    for (int k = 0; k < 5; k++) go(exc_modes[k], 0, 0, 0, 0, 0, 1, 32'h6000_0000 + k, "R7");
    for (int k = 0; k < 5; k++) go(exc_modes[k], 0, 0, 0, 0, 0, 0, 0, "R7");
    go(5'b10010, 0, 0, 0, 0, 0, 1, 32'h6600_0002, "R7");
    for (int k = 0; k < 5; k++) go(exc_modes[k], 0, 0, 0, 0, 0, 0, 0, "R7");

    // R8: ignored outside exception modes
    go(5'b10000, 0, 0, 0, 0, 0, 1, 32'hFFFF_0000, "R8");
    go(5'b11111, 0, 0, 0, 0, 0, 1, 32'hFFFF_1111, "R8");
    go(5'b00101, 0, 0, 0, 0, 0, 1, 32'hFFFF_2222, "R8");
    for (int k = 0; k < 5; k++) go(exc_modes[k], 0, 0, 0, 0, 0, 0, 0, "R8");
    go(5'b10000, 0, 0, 0, 0, 0, 0, 0, "R8");

    // R9: same-cycle read returns old value, next cycle new
    go(5'b10000, 5, 5, 1, 5, 32'h7777_0005, 0, 0, "R9");
    go(5'b10000, 5, 5, 0, 0, 0, 0, 0, "R9");
    go(5'b10001, 9, 9, 1, 9, 32'h7777_0009, 0, 0, "R9");
    go(5'b10001, 9, 9, 0, 0, 0, 0, 0, "R9");

    // R10: program counter index
    pc = 32'h0000_8000;
    go(5'b10000, 15, 3, 0, 0, 0, 0, 0, "R10");
    pc = 32'hCAFE_F00C;
    go(5'b10010, 2, 15, 1, 15, 32'hDEAD_BEEF, 0, 0, "R10");
    go(5'b10010, 13, 14, 0, 0, 0, 0, 0, "R10");
    go(5'b10010, 0, 8, 0, 0, 0, 0, 0, "R10");
    go(5'b10001, 15, 15, 1, 15, 32'h0BAD_CAFE, 0, 0, "R10");
    go(5'b10001, 14, 12, 0, 0, 0, 0, 0, "R10");

    // R11: independent ports under mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] m;
      int r = int'($urandom_range(0, 9));
      m = (r < 7) ? all_modes[r] : 5'($urandom);
      pc = $urandom;
      go(m, int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
         bit'($urandom_range(0, 1)), int'($urandom_range(0, 15)), $urandom,
         bit'($urandom_range(0, 3) == 0), $urandom, "R11");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule